// File: doc/BRIEF.md
# Two-Bank Acquisition Buffer with Lockstep Swap

This block collects hit words from a data-driven detector readout. There is no trigger. A word is stored whenever the front end presents one. Storage is split into two banks. One bank takes incoming words. The other bank is held for the host to drain. When the filling bank takes its last word, the next word goes to the other bank on the very next cycle, so no word is lost. The bank that just filled is frozen and its word count is latched. An interrupt tells the host that a bank is ready.

Several of these buffers work side by side. Each one drives a swap request in the cycle its own bank fills, and each one takes a swap request in from a shared line. A request on that line makes a buffer freeze its bank even when the bank is only partly filled. This way every buffer flushes its bank in the same cycle. The host reads the frozen bank through a synchronous read port. It then pulses a drain-done input, which marks the bank as empty again.

If a swap is due while the other bank still waits for the host, the block raises an overflow flag and drops incoming words. When drain-done arrives, the block completes the swap it owes in that same cycle.

Top module: `pingpong_acq_buf`

## Requirements
- R1: After reset, irq, overflow and swap_req_out are low, frozen_cnt is 0, rd_bank is 1 and words go to bank 0.
- R2: Accepted words are stored in arrival order at addresses 0, 1, 2, ... of the filling bank. After a freeze, a read of address a of the frozen bank returns word a on rd_data one cycle after rd_addr is presented.
- R3: The word that brings the filling bank to DEPTH entries is accepted. swap_req_out is high, combinationally, in that same cycle. From the next cycle on, words go to the other bank and none is lost.
- R4: swap_req_in freezes the filling bank at any fill level, including zero. frozen_cnt then holds the number of words in that bank, counting a word accepted in the same cycle.
- R5: From the cycle after a freeze, irq is high, rd_bank names the frozen bank, and frozen_cnt stays stable until the bank is released.
- R6: drain_done while irq is high clears irq in the next cycle, unless a swap happens in that cycle. drain_done while irq is low has no effect.
- R7: If a swap is due (own fill or swap_req_in) while irq is high and drain_done is low, no swap takes place. overflow goes high in the next cycle, and words offered while overflow is high are dropped.
- R8: drain_done while overflow is high performs the owed swap in that cycle. The current bank is frozen with its count, irq stays high, overflow clears, and the next word goes to address 0 of the released bank.
- R9: A swap that is due in the same cycle as drain_done proceeds without raising overflow.
- R10: swap_req_in while overflow is high is ignored. Freezing and draining alternate between the two banks for as long as acquisition runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | A hit word is present this cycle |
| hit_data | input | DATA_W | Hit word |
| swap_req_in | input | 1 | Shared swap line from peer buffers |
| swap_req_out | output | 1 | This buffer's bank fills this cycle |
| irq | output | 1 | A frozen bank waits for the host |
| overflow | output | 1 | Swap owed while both banks are busy; words dropped |
| rd_bank | output | 1 | Index of the bank the host may read |
| frozen_cnt | output | $clog2(DEPTH+1) | Valid words in the frozen bank |
| rd_addr | input | $clog2(DEPTH) | Host read address |
| rd_data | output | DATA_W | Read data, one cycle after rd_addr |
| drain_done | input | 1 | Host has finished reading the frozen bank |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 32. With banks this small, a random run crosses the full-bank swap hundreds of times. Overflow comes easily when the host holds off draining for a few cycles. The same setting makes it cheap to aim directed hits at the single cycle where the last word, the external swap line and drain-done coincide. Every frozen bank is read back in full and compared word by word against a queue model kept by the bench.

// File: rtl/pab_pkg.sv
package pab_pkg;

  // Reason the fill controller wants to change banks in a given cycle.
  typedef enum logic [1:0] {
    SW_NONE = 2'd0,
    SW_FULL = 2'd1,
    SW_EXT  = 2'd2,
    SW_OWED = 2'd3
  } swap_cause_e;

endpackage

// File: rtl/pab_bank_ram.sv
module pab_bank_ram #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 1024,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pab_fill_ctrl.sv
module pab_fill_ctrl
  import pab_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_valid,
  input  logic          swap_in,
  input  logic          drain_done,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          swap_out,
  output logic          irq,
  output logic          overflow,
  output logic          frz_bank,
  output logic [CW-1:0] frozen_cnt
);

  localparam logic [CW-1:0] LAST_IDX = CW'(DEPTH - 1);

  logic          act_q,  act_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic [CW-1:0] fcnt_q, fcnt_d;
  logic          pend_q, pend_d;
  logic          ovf_q,  ovf_d;

  logic        accept;
  logic        bank_fill;
  logic        drain_ack;
  logic        swap_ok;
  logic        do_swap;
  swap_cause_e cause;

  logic en_act, en_cnt, en_fcnt, en_pend, en_ovf;

  // next-state
  always_comb begin
    accept    = hit_valid && !ovf_q;
    bank_fill = accept && (cnt_q == LAST_IDX);
    drain_ack = drain_done && pend_q;
    swap_ok   = !pend_q || drain_done;

    cause = SW_NONE;
    if (ovf_q) begin
      if (drain_ack) cause = SW_OWED;
    end else if (bank_fill) begin
      cause = SW_FULL;
    end else if (swap_in) begin
      cause = SW_EXT;
    end

    do_swap = (cause != SW_NONE) && swap_ok;

    act_d  = act_q;
    cnt_d  = cnt_q;
    fcnt_d = fcnt_q;
    pend_d = pend_q;
    ovf_d  = ovf_q;

    if (accept) begin
      cnt_d = cnt_q + CW'(1);
    end

    if (do_swap) begin
      act_d  = ~act_q;
      fcnt_d = cnt_q + CW'(accept);
      cnt_d  = '0;
      pend_d = 1'b1;
      ovf_d  = 1'b0;
    end else begin
      if (cause != SW_NONE) ovf_d  = 1'b1;
      if (drain_ack)        pend_d = 1'b0;
    end

    en_act  = do_swap;
    en_cnt  = accept || do_swap;
    en_fcnt = do_swap;
    en_pend = do_swap || drain_ack;
    en_ovf  = do_swap || (cause != SW_NONE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      fcnt_q <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (en_act)  act_q  <= act_d;
      if (en_cnt)  cnt_q  <= cnt_d;
      if (en_fcnt) fcnt_q <= fcnt_d;
      if (en_pend) pend_q <= pend_d;
      if (en_ovf)  ovf_q  <= ovf_d;
    end
  end

  assign wr_en      = accept;
  assign wr_bank    = act_q;
  assign wr_addr    = cnt_q[AW-1:0];
  assign swap_out   = bank_fill;
  assign irq        = pend_q;
  assign overflow   = ovf_q;
  assign frz_bank   = ~act_q;
  assign frozen_cnt = fcnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));  // R2

  AST_FULL_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    swap_out |=> (act_q != $past(act_q)) || overflow);  // R3

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !drain_done) |=> $stable(frozen_cnt) && $stable(frz_bank));  // R5

  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(drain_done));  // R6

  AST_OVF_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> irq && $past(irq));  // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !drain_done) |=> $stable(cnt_q) && overflow);  // R7

  AST_OWED_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && drain_done) |=> !overflow && irq && (cnt_q == '0));  // R8

endmodule

// File: rtl/pingpong_acq_buf.sv
module pingpong_acq_buf #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 1024,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [DATA_W-1:0] hit_data,
  input  logic              swap_req_in,
  output logic              swap_req_out,
  output logic              irq,
  output logic              overflow,
  output logic              rd_bank,
  output logic [CW-1:0]     frozen_cnt,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              drain_done
);

  localparam int NBANK = 2;

  logic              wr_en;
  logic              wr_bank;
  logic [AW-1:0]     wr_addr;
  logic              rsel_q;
  logic [DATA_W-1:0] bank_rdata [NBANK];

  pab_fill_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .swap_in    (swap_req_in),
    .drain_done (drain_done),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .wr_addr    (wr_addr),
    .swap_out   (swap_req_out),
    .irq        (irq),
    .overflow   (overflow),
    .frz_bank   (rd_bank),
    .frozen_cnt (frozen_cnt)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_bank == 1'(g));

    pab_bank_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (bank_we),
      .waddr (wr_addr),
      .wdata (hit_data),
      .raddr (rd_addr),
      .rdata (bank_rdata[g])
    );
  end

  // read-side bank select, aligned with the one-cycle RAM latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= 1'b1;
    end else begin
      rsel_q <= rd_bank;
    end
  end

  assign rd_data = bank_rdata[rsel_q];

endmodule

// File: tb/tb_pingpong_acq_buf.sv
module tb_pingpong_acq_buf;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              hit_valid;
  logic [DATA_W-1:0] hit_data;
  logic              swap_req_in;
  logic              swap_req_out;
  logic              irq;
  logic              overflow;
  logic              rd_bank;
  logic [CW-1:0]     frozen_cnt;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              drain_done;

  always #2 clk = ~clk;  // 250 MHz

  pingpong_acq_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk, .rst_n, .hit_valid, .hit_data, .swap_req_in, .swap_req_out,
    .irq, .overflow, .rd_bank, .frozen_cnt, .rd_addr, .rd_data, .drain_done
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  logic [DATA_W-1:0] m_act [DEPTH];
  logic [DATA_W-1:0] m_frz [DEPTH];
  int m_cnt  = 0;
  int m_fcnt = 0;
  bit m_pend = 0;
  bit m_ovf  = 0;
  bit m_bank = 1;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_full(bit hv);
    return hv && !m_ovf && (m_cnt == DEPTH - 1);
  endfunction

  // model update for one clock, following R2..R10
  task automatic model_step(bit hv, logic [DATA_W-1:0] hd, bit sin, bit dd);
    bit acc, full, ok, evt, owed, dosw;
    acc  = hv && !m_ovf;
    full = exp_full(hv);
    ok   = !m_pend || dd;
    evt  = !m_ovf && (full || sin);
    owed = m_ovf && dd && m_pend;
    dosw = (evt && ok) || owed;
    if (acc) begin
      m_act[m_cnt] = hd;
      m_cnt++;
    end
    if (dosw) begin
      for (int i = 0; i < DEPTH; i++) m_frz[i] = m_act[i];
      m_fcnt = m_cnt;
      m_cnt  = 0;
      m_bank = ~m_bank;
      m_pend = 1;
      m_ovf  = 0;
    end else begin
      if (evt) m_ovf = 1;
      if (dd)  m_pend = 0;
    end
  endtask

  // called right after a negedge; returns right after the following negedge
  task automatic step(bit hv, logic [DATA_W-1:0] hd, bit sin, bit dd, int addr);
    hit_valid   = hv;
    hit_data    = hd;
    swap_req_in = sin;
    drain_done  = dd;
    rd_addr     = AW'(addr);
    #1;
    chk("R3 swap_req_out", swap_req_out, exp_full(hv));
    model_step(hv, hd, sin, dd);
    @(posedge clk);
    @(negedge clk);
    chk("R5 irq", irq, m_pend);
    chk("R7 overflow", overflow, m_ovf);
    chk("R5 rd_bank", rd_bank, m_bank);
    chk("R4 frozen_cnt", frozen_cnt, m_fcnt);
  endtask

  task automatic drain_all(bit release_it);
    for (int i = 0; i < m_fcnt; i++) begin
      step(0, '0, 0, 0, i);
      chk("R2 rd_data", rd_data, m_frz[i]);
    end
    if (release_it) step(0, '0, 0, 1, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int keep;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; hit_valid = 0; hit_data = '0; swap_req_in = 0;
    drain_done = 0; rd_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 swap_req_out", swap_req_out, 0);
    chk("R1 frozen_cnt", frozen_cnt, 0);
    chk("R1 rd_bank", rd_bank, 1);

    // R6: drain_done with nothing frozen is ignored
    step(0, '0, 0, 1, 0);
    chk("R6 idle drain ignored irq", irq, 0);
    chk("R6 idle drain ignored cnt", frozen_cnt, 0);

    // R3: ten back-to-back words across the bank boundary
    for (int i = 0; i < 10; i++) step(1, 32'hA000_0000 + i, 0, 0, 0);
    chk("R3 full bank count", frozen_cnt, DEPTH);
    chk("R3 frozen bank 0", rd_bank, 0);
    drain_all(1);
    chk("R6 irq cleared", irq, 0);

    // R4: external swap with a word in the same cycle (bank 1 holds 2 already)
    step(1, 32'hB000_0001, 0, 0, 0);
    step(1, 32'hB000_0002, 1, 0, 0);
    chk("R4 partial count", frozen_cnt, 4);
    drain_all(0);

    // R7: swap due while bank still waiting -> overflow, words dropped
    step(1, 32'hC000_0001, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R7 overflow set", overflow, 1);
    step(1, 32'hDEAD_0001, 0, 0, 0);
    step(1, 32'hDEAD_0002, 0, 0, 0);
    // R10: swap line ignored during overflow
    step(0, '0, 1, 0, 0);
    chk("R10 ovf swap ignored", frozen_cnt, 4);
    // R8: drain_done performs the owed swap
    step(1, 32'hDEAD_0003, 0, 1, 0);
    chk("R8 overflow cleared", overflow, 0);
    chk("R8 irq held", irq, 1);
    chk("R8 owed count", frozen_cnt, 1);
    drain_all(0);

    // R9: swap and drain_done in the same cycle
    step(1, 32'hE000_0001, 0, 0, 0);
    step(1, 32'hE000_0002, 1, 1, 0);
    chk("R9 no overflow", overflow, 0);
    chk("R9 irq", irq, 1);
    chk("R9 count", frozen_cnt, 2);
    drain_all(1);

    // R4: swap on an empty bank
    step(0, '0, 1, 0, 0);
    chk("R4 empty freeze", frozen_cnt, 0);
    drain_all(1);

    // R10: random acquisition with lazy host
    keep = 0;
    for (int n = 0; n < 4000; n++) begin
      if (m_pend && ($urandom_range(0, 99) < 15)) begin
        drain_all(0);
        step($urandom_range(0, 99) < 70, $urandom, $urandom_range(0, 99) < 5, 1, 0);
        keep++;
      end else begin
        step($urandom_range(0, 99) < 70, $urandom, $urandom_range(0, 99) < 5, 0, 0);
      end
    end
    chk("R10 many swaps", keep > 50, 1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule